// File: doc/BRIEF.md
# PWM Timer with Lockable Shadow Registers

A single-channel pulse-width modulator with a small synchronous register port. Software writes period, duty and output polarity into shadow registers. The running waveform uses a separate committed copy of these values. While the channel runs, the committed copy is loaded from the shadows only when the counter wraps, so a new setting never starts partway through a cycle. A lock bit in the control register blocks that copy. Software can therefore stage several values and release them together. While the channel is stopped and unlocked, the shadows are copied every cycle, so the settings take hold at once.

The counter advances on each cycle in which the prescaler's tick input is high. It counts from zero to period minus one and then wraps. The output is in its active state while the counter is below the committed duty value, and in its inactive state for the rest of the cycle. When the channel is stopped, the output drives a separately chosen idle level. Only continuous, left-aligned operation is implemented. The other control fields are stored and read back but change nothing.

Top module: `pwm_shadow_timer`

## Requirements
- R1: The register offsets are: live counter at 0x0, period at 0x4, duty at 0x8, control at 0xC. After reset, period, duty and counter read 0 and control reads 0x018.
- R2: While running, the counter advances once per cycle with tick high and goes from period-1 back to 0. With tick low it holds its value.
- R3: The output is active while counter < duty and inactive otherwise. Control bit 3 selects the active level (1 = high, 0 = low). The inactive level is its complement.
- R4: A committed duty of 0 gives a constant inactive level. A committed duty greater than or equal to the period gives a constant active level.
- R5: While control bit 6 (lock) is set, writes to period, duty and polarity leave the waveform unchanged.
- R6: After the lock is cleared, the new period, duty and duty polarity take effect together at the next wrap to 0, and not earlier in the current cycle.
- R7: Without the lock, values written while running take effect at the next wrap. Values written while stopped take effect on the second cycle after the write.
- R8: Clearing control bit 0 (run) drives the output to the idle level on the next cycle. Control bit 4 selects that level (1 = high). From the cycle after that, the counter reads 0.
- R9: Writes to the counter offset are ignored. Read data appears on the cycle after the read strobe.
- R10: Control bits 1, 2, 5 and 8 are stored and read back with no effect on the waveform. Bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counter advance enable from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is sampled cycle by cycle against a counter phase the bench tracks itself. It is tried with a mid-range duty, with a duty of zero, and with duties equal to and above the period; these separate the compare boundary from the two constant levels. Both duty polarities are applied, which tells an inverted level from a wrong compare. Reconfiguration is tried while locked, on unlock partway through a cycle, and unlocked partway through a cycle. Each case shows whether new values leak in before the wrap.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int OFS_COUNT  = 0;
  localparam int OFS_PERIOD = 4;
  localparam int OFS_DUTY   = 8;
  localparam int OFS_CTRL   = 12;

  localparam int BIT_RUN  = 0;
  localparam int BIT_DPOL = 3;
  localparam int BIT_IPOL = 4;
  localparam int BIT_LOCK = 6;

  localparam int CTRL_W = 9;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h018;
  localparam logic [CTRL_W-1:0] CTRL_KEEP  = 9'h17F;

  // last count of a cycle: a zero period wraps on every tick
  function automatic logic is_last(input logic [31:0] cnt, input logic [31:0] per);
    return (per == 32'd0) || (({1'b0, cnt} + 33'd1) >= {1'b0, per});
  endfunction

  // output level for a given count while running
  function automatic logic run_level(input logic [31:0] cnt, input logic [31:0] duty,
                                     input logic dpol);
    return (cnt < duty) ? dpol : ~dpol;
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              commit,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              run_q,
  output logic              lock_q,
  output logic [CNT_W-1:0]  per_act,
  output logic [CNT_W-1:0]  duty_act,
  output logic              dpol_act,
  output logic              ipol_act
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_sh;
  logic [CNT_W-1:0]  duty_sh;
  logic [CNT_W-1:0]  rd_mux;
  logic sel_cnt, sel_per, sel_duty, sel_ctrl;

  assign sel_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign sel_per  = (bus_addr == ADDR_W'(OFS_PERIOD));
  assign sel_duty = (bus_addr == ADDR_W'(OFS_DUTY));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

  assign run_q  = ctrl_q[BIT_RUN];
  assign lock_q = ctrl_q[BIT_LOCK];

  // shadow side: written by software at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      per_sh  <= '0;
      duty_sh <= '0;
    end else if (bus_wr) begin
      if (sel_per)  per_sh  <= bus_wdata;
      if (sel_duty) duty_sh <= bus_wdata;
      if (sel_ctrl) ctrl_q  <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  // committed side: loaded only on commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act  <= '0;
      duty_act <= '0;
      dpol_act <= CTRL_RESET[BIT_DPOL];
      ipol_act <= CTRL_RESET[BIT_IPOL];
    end else if (commit) begin
      per_act  <= per_sh;
      duty_act <= duty_sh;
      dpol_act <= ctrl_q[BIT_DPOL];
      ipol_act <= ctrl_q[BIT_IPOL];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_cnt)       rd_mux = live_cnt;
    else if (sel_per)  rd_mux = per_sh;
    else if (sel_duty) rd_mux = duty_sh;
    else if (sel_ctrl) rd_mux = CNT_W'(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic last;

  assign last = is_last(32'(cnt_q), 32'(per_act));
  assign wrap = run & tick & last;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (tick)      cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_act,
  input  logic             dpol_act,
  input  logic             ipol_act,
  output logic             pwm_out
);
  assign pwm_out = run ? run_level(32'(cnt), 32'(duty_act), dpol_act) : ipol_act;
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  logic             run_q, lock_q, wrap, commit;
  logic [CNT_W-1:0] cnt_q, per_act, duty_act;
  logic             dpol_act, ipol_act;

  // commit at wrap while running, every cycle while stopped, never while locked
  assign commit = ~lock_q & (~run_q | wrap);

  pwm_regfile #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .live_cnt(cnt_q),
    .commit(commit), .bus_rdata(bus_rdata), .run_q(run_q), .lock_q(lock_q),
    .per_act(per_act), .duty_act(duty_act), .dpol_act(dpol_act),
    .ipol_act(ipol_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick_en),
    .per_act(per_act), .cnt_q(cnt_q), .wrap(wrap)
  );

  pwm_outstage #(.CNT_W(CNT_W)) u_out (
    .run(run_q), .cnt(cnt_q), .duty_act(duty_act),
    .dpol_act(dpol_act), .ipol_act(ipol_act), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_shadow_timer_chk.sv
module pwm_shadow_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             lock_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] duty_act,
  input logic             dpol_act,
  input logic             ipol_act,
  input logic             pwm_out
);
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && per_act != '0) |-> (cnt_q < per_act)); // R2

  AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && duty_act == '0) |-> (pwm_out == ~dpol_act)); // R4

  AST_FULL_DUTY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && per_act != '0 && duty_act >= per_act) |-> (pwm_out == dpol_act)); // R4

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(per_act) && $stable(duty_act) && $stable(dpol_act))); // R5

  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && (per_act != $past(per_act) || duty_act != $past(duty_act)))
      |-> (cnt_q == '0)); // R6

  AST_STOP_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0)); // R8

  AST_STOP_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_out == ipol_act)); // R8
endmodule

bind pwm_shadow_timer pwm_shadow_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .lock_q(lock_q), .cnt_q(cnt_q),
  .per_act(per_act), .duty_act(duty_act), .dpol_act(dpol_act),
  .ipol_act(ipol_act), .pwm_out(pwm_out)
);

// File: tb/pwm_shadow_timer_test.sv
module pwm_shadow_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        pwm_out;
  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm_shadow_timer #(.CNT_W(16), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // expected level per count, checked for n cycles from phase 'first'
  task automatic wave(input string req, input int p, input int d, input logic pol,
                      input int first, input int n);
    for (int k = 0; k < n; k++) begin
      int c = (first + k) % p;
      chk(req, {31'd0, pwm_out}, {31'd0, (c < d) ? pol : ~pol});
      @(negedge clk);
    end
  endtask

  // bring the counter to zero: freeze, read phase, run out the rest
  task automatic sync_zero(input int p);
    logic [15:0] c;
    tick_en = 1'b0;
    rd(4'h0, c);
    tick_en = 1'b1;
    repeat (p - int'(c)) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R8 idle after reset", {31'd0, pwm_out}, 32'd1);
    rd(4'hC, v); chk("R1 ctrl reset", {16'd0, v}, 32'h018);
    rd(4'h4, v); chk("R1 period reset", {16'd0, v}, 32'd0);
    rd(4'h8, v); chk("R1 duty reset", {16'd0, v}, 32'd0);
    rd(4'h0, v); chk("R1 counter reset", {16'd0, v}, 32'd0);
  endtask

  task automatic t_basic;
    logic [15:0] v;
    wr(4'h4, 16'd8);
    wr(4'h8, 16'd3);
    rd(4'h4, v); chk("R1 period readback", {16'd0, v}, 32'd8);
    wr(4'hC, 16'h019);
    wave("R3 normal wave", 8, 3, 1'b1, 0, 16);
  endtask

  task automatic t_hold;
    logic [15:0] c1, c2;
    tick_en = 1'b0;
    rd(4'h0, c1);
    repeat (3) @(negedge clk);
    rd(4'h0, c2); chk("R2 hold without tick", {16'd0, c2}, {16'd0, c1});
    wr(4'h0, 16'd5);
    rd(4'h0, c2); chk("R9 counter write ignored", {16'd0, c2}, {16'd0, c1});
    tick_en = 1'b1;
  endtask

  task automatic t_extremes;
    wr(4'h8, 16'd0); sync_zero(8);
    wave("R4 duty zero", 8, 0, 1'b1, 0, 8);
    wr(4'h8, 16'd8); sync_zero(8);
    wave("R4 duty equals period", 8, 8, 1'b1, 0, 8);
    wr(4'h8, 16'd12); sync_zero(8);
    wave("R4 duty above period", 8, 12, 1'b1, 0, 8);
  endtask

  task automatic t_invert;
    wr(4'h8, 16'd3);
    wr(4'hC, 16'h011);
    sync_zero(8);
    wave("R3 inverted wave", 8, 3, 1'b0, 0, 8);
  endtask

  task automatic t_lock;
    wr(4'hC, 16'h051);
    wr(4'h4, 16'd5);
    wr(4'h8, 16'd2);
    sync_zero(8);
    wave("R5 locked keeps old", 8, 3, 1'b0, 0, 8);
    repeat (2) @(negedge clk);
    wr(4'hC, 16'h019);
    wave("R6 rest of cycle old", 8, 3, 1'b0, 3, 5);
    wave("R6 new set at wrap", 5, 2, 1'b1, 0, 10);
  endtask

  task automatic t_unlocked_mid;
    @(negedge clk);
    wr(4'h8, 16'd4);
    wave("R7 running write waits", 5, 2, 1'b1, 2, 3);
    wave("R7 applied at wrap", 5, 4, 1'b1, 0, 5);
  endtask

  task automatic t_stop;
    logic [15:0] v;
    repeat (2) @(negedge clk);
    wr(4'hC, 16'h018);
    chk("R8 idle high at stop", {31'd0, pwm_out}, 32'd1);
    @(negedge clk);
    rd(4'h0, v); chk("R8 counter cleared", {16'd0, v}, 32'd0);
    wr(4'hC, 16'h000);
    @(negedge clk);
    chk("R7 stopped applies at once", {31'd0, pwm_out}, 32'd0);
    wr(4'hC, 16'h1A6);
    rd(4'hC, v); chk("R10 spare bits readback", {16'd0, v}, 32'h126);
    chk("R10 spare bits no effect", {31'd0, pwm_out}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_extremes();
    t_invert();
    t_lock();
    t_unlocked_mid();
    t_stop();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule